// File: doc/BRIEF.md
# Posted-Store Buffer with Read Forwarding

This block sits between a data cache and main memory and holds stores that the processor has already issued. The processor does not wait for each slow memory write to finish. The buffer keeps up to `DEPTH` address/data pairs and writes them to a single memory port in the order they arrived. When a line is evicted on a read miss, its store can enter the buffer in the same cycle that the refill read goes out.

Each read miss on its way to memory is looked up against every live entry at once. If an address matches, the newest matching entry answers the read in the same cycle and memory is not read. If no address matches, the read goes to memory at once, without waiting for the buffer to drain. In that cycle it takes the memory port ahead of any pending drain write.

The memory port uses a request/acknowledge handshake. A transfer completes in the cycle where `mem_req` and `mem_ack` are both high. A read requester holds `rd_valid` and `rd_addr` until `rd_done` is seen. `DEPTH` must be a power of two.

Top module: `store_buffer`

## Requirements
- R1: After reset the buffer is empty, `st_ready` is 1, `mem_req` is 0 and `rd_done` is 0.
- R2: The buffer holds `DEPTH` (default 4) entries. When it is full, `st_ready` is 0, and a store offered on `st_valid` is dropped: it is never forwarded and never written to memory.
- R3: Drain writes (`mem_req`=1, `mem_we`=1) carry the oldest entry's address and data. An entry leaves the buffer only in a cycle where `mem_ack` is 1, so writes reach memory in enqueue order.
- R4: An empty buffer issues no memory write.
- R5: A read whose `rd_addr` equals the address of any live entry gets `rd_hit`=1, `rd_done`=1 and the buffered data on `rd_data`, all in the same cycle, and no memory read is issued for it.
- R6: When several live entries hold the read address, the most recently enqueued one supplies `rd_data`.
- R7: A read that matches no entry drives `mem_req`=1, `mem_we`=0, `mem_addr`=`rd_addr` at once, even when the buffer is not empty. It completes with `rd_done`=1, `rd_hit`=0 and `rd_data`=`mem_rdata` in the cycle of `mem_ack`.
- R8: When a memory read and a drain write are both pending in one cycle, the read gets the memory port and no entry is removed in that cycle.
- R9: A cycle that both enqueues and drains an entry leaves the occupancy unchanged.
- R10: Once an entry has been written to memory, it no longer answers reads to its address.
- R11: A store is accepted in the same cycle that a read miss is being sent to memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Buffer can accept a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| rd_valid | input | 1 | Read miss lookup request, held until `rd_done` |
| rd_addr | input | AW | Read address |
| rd_hit | output | 1 | Read served from the buffer |
| rd_done | output | 1 | Read data valid this cycle |
| rd_data | output | DW | Read data |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = drain write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data |
| mem_ack | input | 1 | Memory completes the transfer this cycle |

## Verification
A table of stores and reads separates three read cases:
- a single matching entry;
- an address stored twice, where only newest-first selection returns the later data;
- an address never stored, which must fall through to memory.

Directed sequences then cover the boundary cases:
- A store offered to a full buffer is followed by a read of that address, which shows whether the store was dropped.
- A read miss is raised while a drain is acknowledged, which shows whether the port is arbitrated correctly.
- A store is made in the same cycle as a drain, and another in the same cycle as a read miss. Full-flag timing afterwards shows whether the occupancy count stayed correct.
- A full drain is logged and compared with the enqueue order.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [1:0] {
        GRANT_IDLE  = 2'd0,
        GRANT_READ  = 2'd1,
        GRANT_DRAIN = 2'd2
    } grant_e;

endpackage

// File: rtl/sb_lookup.sv
// Associative probe of all live slots; the newest matching slot wins.
module sb_lookup #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int PW    = 2,
    parameter int CW    = 3
) (
    input  logic [DEPTH-1:0][AW-1:0] slot_addr,
    input  logic [DEPTH-1:0][DW-1:0] slot_data,
    input  logic [PW-1:0]            head,
    input  logic [CW-1:0]            count,
    input  logic [AW-1:0]            probe_addr,
    output logic                     hit,
    output logic [DW-1:0]            hit_data
);

    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] match;
    logic [DEPTH-1:0][PW-1:0] age;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        assign age[i]   = PW'(i) - head;
        assign live[i]  = ({1'b0, age[i]} < {1'b0, count});
        assign match[i] = live[i] && (slot_addr[i] == probe_addr);
    end

    logic [PW-1:0] best_age;

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        best_age = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i] && (!hit || age[i] > best_age)) begin
                hit      = 1'b1;
                hit_data = slot_data[i];
                best_age = age[i];
            end
        end
    end

endmodule

// File: rtl/sb_arbiter.sv
// Memory port arbitration: a read miss always goes before a drain write.
module sb_arbiter
    import sb_pkg::*;
(
    input  logic   read_pend,
    input  logic   drain_pend,
    output grant_e grant
);

    always_comb begin
        if (read_pend)       grant = GRANT_READ;
        else if (drain_pend) grant = GRANT_DRAIN;
        else                 grant = GRANT_IDLE;
    end

endmodule

// File: rtl/store_buffer.sv
module store_buffer
    import sb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_hit,
    output logic          rd_done,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [PW-1:0]            head;
        logic [PW-1:0]            tail;
        logic [CW-1:0]            count;
    } buf_state_t;

    buf_state_t buf_d, buf_q;

    logic          fwd_hit;
    logic [DW-1:0] fwd_data;
    logic          read_miss;
    logic          push, pop;
    grant_e        grant;
    logic [CW-1:0] fill_lvl;

    sb_lookup #(
        .DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW), .CW(CW)
    ) lookup_i (
        .slot_addr (buf_q.addr),
        .slot_data (buf_q.data),
        .head      (buf_q.head),
        .count     (buf_q.count),
        .probe_addr(rd_addr),
        .hit       (fwd_hit),
        .hit_data  (fwd_data)
    );

    assign read_miss = rd_valid && !fwd_hit;

    sb_arbiter arb_i (
        .read_pend (read_miss),
        .drain_pend(buf_q.count != '0),
        .grant     (grant)
    );

    assign fill_lvl = buf_q.count;
    assign st_ready = (buf_q.count != CW'(DEPTH));
    assign push     = st_valid && st_ready;
    assign pop      = (grant == GRANT_DRAIN) && mem_ack;

    assign mem_req   = (grant != GRANT_IDLE);
    assign mem_we    = (grant == GRANT_DRAIN);
    assign mem_addr  = (grant == GRANT_READ) ? rd_addr : buf_q.addr[buf_q.head];
    assign mem_wdata = buf_q.data[buf_q.head];

    assign rd_hit  = rd_valid && fwd_hit;
    assign rd_done = rd_valid && (fwd_hit || ((grant == GRANT_READ) && mem_ack));
    assign rd_data = fwd_hit ? fwd_data : mem_rdata;

    always_comb begin
        buf_d = buf_q;
        if (push) begin
            buf_d.addr[buf_q.tail] = st_addr;
            buf_d.data[buf_q.tail] = st_data;
            buf_d.tail             = buf_q.tail + 1'b1;
        end
        if (pop) begin
            buf_d.head = buf_q.head + 1'b1;
        end
        case ({push, pop})
            2'b10:   buf_d.count = buf_q.count + 1'b1;
            2'b01:   buf_d.count = buf_q.count - 1'b1;
            default: buf_d.count = buf_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         st_valid,
    input logic                         st_ready,
    input logic                         rd_valid,
    input logic [AW-1:0]                rd_addr,
    input logic                         rd_hit,
    input logic                         rd_done,
    input logic [DW-1:0]                rd_data,
    input logic                         mem_req,
    input logic                         mem_we,
    input logic [AW-1:0]                mem_addr,
    input logic [DW-1:0]                mem_wdata,
    input logic [DW-1:0]                mem_rdata,
    input logic                         mem_ack,
    input logic [$clog2(DEPTH+1)-1:0]   fill_lvl
);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= DEPTH); // R2

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_ready) |=> fill_lvl <= $past(fill_lvl)); // R2

    AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_ack) |=>
            mem_req && (!mem_we || ($stable(mem_addr) && $stable(mem_wdata)))); // R3

    AST_EMPTY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl == 0) |-> !(mem_req && mem_we)); // R4

    AST_HIT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_hit) |-> rd_done && !(mem_req && !mem_we)); // R5

    AST_MISS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hit && mem_ack) |-> rd_done && (rd_data == mem_rdata)); // R7

    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_hit) |-> mem_req && !mem_we && (mem_addr == rd_addr)); // R8

    AST_SWAP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && st_ready && mem_req && mem_we && mem_ack) |=>
            fill_lvl == $past(fill_lvl)); // R9

endmodule

bind store_buffer sb_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_valid (st_valid),
    .st_ready (st_ready),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_hit   (rd_hit),
    .rd_done  (rd_done),
    .rd_data  (rd_data),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata),
    .mem_ack  (mem_ack),
    .fill_lvl (fill_lvl)
);

// File: tb/store_buffer_tb_top.sv
module store_buffer_tb_top;

    localparam logic [31:0] MAGIC = 32'hC0DE_0000;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n, st_valid, st_ready, rd_valid, rd_hit, rd_done;
    logic        mem_req, mem_we, mem_ack, rack, wack;
    logic [31:0] st_addr, st_data, rd_addr, rd_data, mem_addr, mem_wdata, mem_rdata;

    assign mem_rdata = mem_addr ^ MAGIC;
    assign mem_ack   = mem_req && (mem_we ? wack : rack);

    store_buffer dut_i (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_hit(rd_hit), .rd_done(rd_done),
        .rd_data(rd_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done_flag = 0;

    logic [31:0] log_a [16];
    logic [31:0] log_d [16];
    int log_n = 0;

    always @(posedge clk) begin
        if (rst_n && mem_req && mem_we && mem_ack && log_n < 16) begin
            log_a[log_n] <= mem_addr;
            log_d[log_n] <= mem_wdata;
            log_n <= log_n + 1;
        end
    end

    typedef struct packed {
        logic        is_rd;
        logic [31:0] a;
        logic [31:0] d;
        logic        hit;
    } vec_t;

    localparam vec_t VEC [9] = '{
        '{1'b0, 32'h100, 32'h11, 1'b0},
        '{1'b0, 32'h200, 32'h22, 1'b0},
        '{1'b1, 32'h100, 32'h11, 1'b1},
        '{1'b0, 32'h100, 32'h33, 1'b0},
        '{1'b1, 32'h100, 32'h33, 1'b1},
        '{1'b1, 32'h300, 32'h0,  1'b0},
        '{1'b1, 32'h200, 32'h22, 1'b1},
        '{1'b0, 32'h400, 32'h44, 1'b0},
        '{1'b1, 32'h400, 32'h44, 1'b1}
    };

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic rv, input logic [31:0] ra, input logic sv,
                         input logic [31:0] sa, input logic [31:0] sd,
                         input logic rk, input logic wk);
        @(negedge clk);
        rd_valid = rv; rd_addr = ra;
        st_valid = sv; st_addr = sa; st_data = sd;
        rack = rk; wack = wk;
        #1;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        finish_run();
    end

    logic [31:0] exp_a [6] = '{32'h100, 32'h200, 32'h100, 32'h400, 32'h700, 32'h900};
    logic [31:0] exp_d [6] = '{32'h11, 32'h22, 32'h33, 32'h44, 32'h77, 32'h99};

    initial begin
        rst_n = 0; st_valid = 0; rd_valid = 0; st_addr = 0; st_data = 0;
        rd_addr = 0; rack = 0; wack = 0;
        repeat (3) @(posedge clk);
        drive(0, 0, 0, 0, 0, 1, 1);
        rst_n = 1;
        #1;
        // R1 reset state
        check(st_ready == 1'b1, "R1 st_ready", 32'(st_ready), 32'd1);
        check(mem_req == 1'b0, "R1 mem_req", 32'(mem_req), 32'd0);
        check(rd_done == 1'b0, "R1 rd_done", 32'(rd_done), 32'd0);

        // table walk: stores, forwarded hits (R5), newest wins (R6), miss (R7)
        for (int i = 0; i < 9; i++) begin
            if (VEC[i].is_rd) begin
                logic [31:0] e;
                e = VEC[i].hit ? VEC[i].d : (VEC[i].a ^ MAGIC);
                drive(1, VEC[i].a, 0, 0, 0, 1, 0);
                check(rd_done && rd_hit == VEC[i].hit, "R5/R6/R7 hit flag",
                      32'(rd_hit), 32'(VEC[i].hit));
                check(rd_data == e, "R5/R6/R7 read data", rd_data, e);
            end else begin
                drive(0, 0, 1, VEC[i].a, VEC[i].d, 1, 0);
                check(st_ready == 1'b1, "R2 store accepted", 32'(st_ready), 32'd1);
            end
        end

        // R2 full stall and dropped store
        drive(0, 0, 0, 0, 0, 1, 0);
        check(st_ready == 1'b0, "R2 full st_ready", 32'(st_ready), 32'd0);
        drive(0, 0, 1, 32'h500, 32'h55, 1, 0);
        drive(1, 32'h500, 0, 0, 0, 1, 0);
        check(rd_done && !rd_hit && rd_data == (32'h500 ^ MAGIC), "R2 dropped store",
              rd_data, 32'h500 ^ MAGIC);

        // R8 read beats drain
        drive(1, 32'h600, 0, 0, 0, 1, 1);
        check(mem_req && !mem_we && mem_addr == 32'h600, "R8 read granted",
              mem_addr, 32'h600);
        drive(0, 0, 0, 0, 0, 1, 0);
        check(log_n == 0, "R8 no drain", 32'(log_n), 32'd0);
        // R3 head presented and held without ack
        check(mem_we && mem_addr == 32'h100 && mem_wdata == 32'h11, "R3 head",
              mem_addr, 32'h100);
        drive(0, 0, 0, 0, 0, 1, 0);
        check(mem_we && mem_addr == 32'h100 && mem_wdata == 32'h11, "R3 hold",
              mem_wdata, 32'h11);

        // one drain, then store and drain in the same cycle
        drive(0, 0, 0, 0, 0, 1, 1);
        drive(0, 0, 1, 32'h700, 32'h77, 1, 1);
        check(st_ready == 1'b1, "R9 room before swap", 32'(st_ready), 32'd1);
        // R11 store during read miss
        drive(1, 32'h800, 1, 32'h900, 32'h99, 1, 0);
        check(st_ready == 1'b1, "R9 level kept by swap", 32'(st_ready), 32'd1);
        check(rd_done && !rd_hit && !mem_we && rd_data == (32'h800 ^ MAGIC),
              "R11 read miss with store", rd_data, 32'h800 ^ MAGIC);
        drive(0, 0, 0, 0, 0, 1, 0);
        check(st_ready == 1'b0, "R11 store taken, buffer full", 32'(st_ready), 32'd0);
        check(log_n == 2, "R9 drained count", 32'(log_n), 32'd2);

        // drain all
        repeat (6) drive(0, 0, 0, 0, 0, 1, 1);
        check(log_n == 6, "R3 total writes", 32'(log_n), 32'd6);
        for (int i = 0; i < 6; i++) begin
            check(log_a[i] == exp_a[i] && log_d[i] == exp_d[i], "R3 order",
                  log_a[i], exp_a[i]);
        end
        // R4 empty: no writes even with ack enabled
        check(mem_req == 1'b0, "R4 idle", 32'(mem_req), 32'd0);
        drive(0, 0, 0, 0, 0, 1, 1);
        check(mem_req == 1'b0 && log_n == 6, "R4 still idle", 32'(log_n), 32'd6);

        // R10 drained entry no longer forwards
        drive(1, 32'h400, 0, 0, 0, 1, 0);
        check(rd_done && !rd_hit && rd_data == (32'h400 ^ MAGIC), "R10 drained miss",
              rd_data, 32'h400 ^ MAGIC);
        drive(0, 0, 0, 0, 0, 0, 0);

        finish_run();
    end

endmodule